// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Channel with Timestamp Counter

This block is one external interrupt channel. A select field routes one of several general-purpose input pins into the channel. The chosen level passes through a two-flop synchronizer, and an edge detector then watches it for a falling transition, a rising transition or either one, as a two-bit mode field directs. When the channel is enabled, each qualifying transition produces a single-cycle request on the interrupt output.

A 16-bit up counter runs on every clock cycle. It restarts from zero in the same cycle that a request is issued. Software that services the interrupt and reads the counter therefore sees how many cycles have passed since the event. Read again at the next event, the counter gives the spacing between successive events. When the channel is disabled, the counter keeps counting and is never cleared. The interrupt controller and any other pin multiplexing belong to the surrounding chip.

Top module: `ext_irq_stamp`

## Requirements
- R1: While rst_n is low, irq_o is 0 and stamp_o is 0.
- R2: stamp_o rises by one on every clock cycle that carries no request, and it wraps from 0xFFFF to 0x0000 without raising irq_o.
- R3: With cfg_mode_i = 2'b00, a 1-to-0 transition of the selected pin raises a request and a 0-to-1 transition does not.
- R4: With cfg_mode_i = 2'b01, a 0-to-1 transition of the selected pin raises a request and a 1-to-0 transition does not.
- R5: With cfg_mode_i[1] = 1 (2'b10 or 2'b11), transitions in both directions raise a request.
- R6: Suppose a pin level change is presented before a rising clock edge. irq_o is high after the third rising edge counted from that one, and it stays high for exactly one cycle.
- R7: While cfg_en_i is low, irq_o stays 0. Pin transitions do not clear stamp_o, which keeps counting.
- R8: In the cycle irq_o is high, stamp_o reads 0. In the following cycle it reads 1.
- R9: cfg_sel_i picks pin pins_i[cfg_sel_i] as the source. Transitions on any other pin neither raise irq_o nor clear stamp_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS (16) | General-purpose input pins |
| cfg_en_i | input | 1 | Channel enable |
| cfg_mode_i | input | 2 | Edge mode: 00 falling, 01 rising, 1x both |
| cfg_sel_i | input | SEL_W (4) | Index of the source pin |
| irq_o | output | 1 | Single-cycle interrupt request |
| stamp_o | output | CNT_W (16) | Free-running timestamp counter |

## Verification
If the synchronizer or the previous-level register holds a wrong value, the effect shows up at the ports within three cycles of a pin change. irq_o fires on the wrong polarity, fires on the wrong cycle or misses an event, and stamp_o fails to restart at zero alongside it. A fault in the counter breaks the plus-one step on the very next cycle. A wrap fault becomes visible at the single cycle after 0xFFFF. A routing fault appears as a request, or a counter clear, caused by a pin other than the selected one. Each stimulus is therefore followed by checks of both outputs at the exact predicted cycle and at the cycle after it.

// File: rtl/irq_stamp_pkg.sv
package irq_stamp_pkg;
    typedef logic [1:0] edge_mode_t;

    localparam edge_mode_t MODE_FALL = 2'b00;
    localparam edge_mode_t MODE_RISE = 2'b01;
    localparam int         MODE_BOTH_BIT = 1;

    typedef struct packed {
        logic prev;
        logic irq;
    } edge_state_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int NUM_PINS = 16,
    parameter int SEL_W    = 4,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic                level_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic        picked;

    always_comb begin
        picked = pins_i[sel_i];
        st_d   = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], picked};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
    import irq_stamp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  logic       en_i,
    input  edge_mode_t mode_i,
    output logic       hit_o,
    output logic       irq_o
);
    edge_state_t st_d, st_q;
    logic rise, fall, match;

    always_comb begin
        rise  = level_i & ~st_q.prev;
        fall  = ~level_i & st_q.prev;
        if (mode_i[MODE_BOTH_BIT])   match = rise | fall;
        else if (mode_i == MODE_RISE) match = rise;
        else                          match = fall;
        hit_o     = en_i & match;
        st_d      = st_q;
        st_d.prev = level_i;
        st_d.irq  = hit_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_stamp_ctr.sv
module irq_stamp_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) st_d.count = '0;
        else         st_d.count = st_q.count + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
endmodule

// File: rtl/ext_irq_stamp.sv
module ext_irq_stamp
    import irq_stamp_pkg::*;
#(
    parameter int NUM_PINS    = 16,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                cfg_en_i,
    input  logic [1:0]          cfg_mode_i,
    input  logic [SEL_W-1:0]    cfg_sel_i,
    output logic                irq_o,
    output logic [CNT_W-1:0]    stamp_o
);
    logic level;
    logic hit;

    irq_pin_sync #(
        .NUM_PINS (NUM_PINS),
        .SEL_W    (SEL_W),
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  (pins_i),
        .sel_i   (cfg_sel_i),
        .level_o (level)
    );

    irq_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level),
        .en_i    (cfg_en_i),
        .mode_i  (cfg_mode_i),
        .hit_o   (hit),
        .irq_o   (irq_o)
    );

    irq_stamp_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (hit),
        .count_o (stamp_o)
    );
endmodule

// File: rtl/ext_irq_stamp_chk.sv
module ext_irq_stamp_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en_i,
    input logic             irq_o,
    input logic [CNT_W-1:0] stamp_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !irq_o) |-> (stamp_o == CNT_W'($past(stamp_o) + 1'b1))); // R2

    AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(cfg_en_i)) |-> !irq_o); // R7

    AST_STAMP_ZERO_AT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stamp_o == '0)); // R8

    AST_STAMP_ONE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(irq_o) && !irq_o) |-> (stamp_o == CNT_W'(1))); // R8
endmodule

bind ext_irq_stamp ext_irq_stamp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en_i (cfg_en_i),
    .irq_o    (irq_o),
    .stamp_o  (stamp_o)
);

// File: tb/tb_ext_irq_stamp.sv
module tb_ext_irq_stamp;
    localparam int NP = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          en = 1'b0;
    logic [1:0]    mode = 2'b01;
    logic [3:0]    sel = '0;
    logic          irq;
    logic [CW-1:0] stamp;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ext_irq_stamp dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .cfg_en_i(en),
        .cfg_mode_i(mode), .cfg_sel_i(sel), .irq_o(irq), .stamp_o(stamp)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive one pin at a negedge, check both outputs three and four cycles later.
    task automatic edge_step(input int pin, input logic val, input bit exp, input string tag);
        logic [CW-1:0] s0;
        @(negedge clk);
        s0 = stamp;
        pins[pin] = val;
        tick(3);
        chk(irq == exp, {tag, " irq at third edge"}, irq, exp);
        if (exp) chk(stamp == 0, {tag, " R8 stamp zero"}, stamp, 0);
        else     chk(stamp == CW'(s0 + 3), {tag, " stamp not cleared"}, stamp, CW'(s0 + 3));
        tick(1);
        chk(irq == 1'b0, {tag, " R6 one-cycle pulse"}, irq, 0);
        if (exp) chk(stamp == 1, {tag, " R8 stamp one"}, stamp, 1);
        else     chk(stamp == CW'(s0 + 4), {tag, " stamp keeps counting"}, stamp, CW'(s0 + 4));
    endtask

    task automatic t_reset();
        tick(2);
        chk(irq == 0, "R1 irq in reset", irq, 0);
        chk(stamp == 0, "R1 stamp in reset", stamp, 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        chk(stamp == 1, "R2 first count", stamp, 1);
    endtask

    task automatic t_wrap();
        int guard = 0;
        while (stamp != 16'hFFFF && guard < 70000) begin
            tick(1);
            guard++;
        end
        chk(stamp == 16'hFFFF, "R2 reach max", stamp, 16'hFFFF);
        tick(1);
        chk(stamp == 0, "R2 wrap to zero", stamp, 0);
        chk(irq == 0, "R2 no irq on wrap", irq, 0);
    endtask

    task automatic t_rising();
        mode = 2'b01; en = 1'b1; sel = 4'd0;
        tick(4);
        edge_step(0, 1'b1, 1, "R4 rise");
        edge_step(0, 1'b0, 0, "R4 fall ignored");
        edge_step(0, 1'b1, 1, "R6 rise latency");
        edge_step(0, 1'b0, 0, "R4 fall ignored again");
    endtask

    task automatic t_falling();
        mode = 2'b00;
        tick(4);
        edge_step(0, 1'b1, 0, "R3 rise ignored");
        edge_step(0, 1'b0, 1, "R3 fall");
    endtask

    task automatic t_both();
        mode = 2'b10;
        tick(4);
        edge_step(0, 1'b1, 1, "R5 rise mode10");
        edge_step(0, 1'b0, 1, "R5 fall mode10");
        mode = 2'b11;
        tick(4);
        edge_step(0, 1'b1, 1, "R5 rise mode11");
        edge_step(0, 1'b0, 1, "R5 fall mode11");
    endtask

    task automatic t_disabled();
        mode = 2'b10; en = 1'b0;
        tick(4);
        edge_step(0, 1'b1, 0, "R7 rise while off");
        edge_step(0, 1'b0, 0, "R7 fall while off");
        en = 1'b1;
        tick(4);
        edge_step(0, 1'b1, 1, "R7 re-enabled");
        edge_step(0, 1'b0, 1, "R7 re-enabled fall");
    endtask

    task automatic t_select();
        mode = 2'b10; en = 1'b1;
        sel = 4'd3;
        tick(4);
        edge_step(5, 1'b1, 0, "R9 other pin rise");
        edge_step(5, 1'b0, 0, "R9 other pin fall");
        edge_step(3, 1'b1, 1, "R9 selected pin rise");
        edge_step(0, 1'b1, 0, "R9 old pin ignored");
        edge_step(3, 1'b0, 1, "R9 selected pin fall");
        pins[0] = 1'b0;
        sel = 4'd15;
        tick(4);
        edge_step(15, 1'b1, 1, "R9 top pin rise");
    endtask

    initial begin
        t_reset();
        t_wrap();
        t_rising();
        t_falling();
        t_both();
        t_disabled();
        t_select();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule